// File: doc/BRIEF.md
# Burst Address Counter Unit

This block produces the array address for one port of a synchronous memory. On every rising clock edge it picks the address for the current access from four candidates: zero, the address on the external bus, the held count plus one, or the held count itself. The picked value goes to the array decoder in the same cycle. It is also captured in the counter register, so a burst can go on without the external bus being driven again.

Three active-low controls choose the source, and they have a fixed priority. Clear is strongest, then strobe, then advance. When all three are high, the counter keeps its value. A clear or a load can land in the same cycle as a normal read or write, and no idle cycle is needed. Chip selects, data paths and the array itself are outside this block. The address width is a parameter.

Top module: `burst_addr_gen`

## Requirements
- R1: After `rst_ni` is released, `count_o` is zero until a control input changes it.
- R2: When `clr_ni` is low, `int_addr_o` is zero in that cycle and `count_o` is zero after the edge, whatever `strobe_ni`, `adv_ni` and `ext_addr_i` are.
- R3: When `strobe_ni` is low and `clr_ni` is high, `count_o` takes the value of `ext_addr_i` at the edge.
- R4: When `adv_ni` is low and both `strobe_ni` and `clr_ni` are high, `int_addr_o` is the held count plus one, and `count_o` takes that value at the edge.
- R5: While `strobe_ni` or `clr_ni` is low, `adv_ni` has no effect on either output.
- R6: With all three controls high, `count_o` keeps its value, `int_addr_o` equals `count_o`, and `ext_addr_i` has no effect.
- R7: Advancing from the all-ones address gives zero.
- R8: When `strobe_ni` is low and `clr_ni` is high, `int_addr_o` equals `ext_addr_i` in the same cycle.
- R9: A clear cycle followed by an advance cycle presents address 0 and then address 1 on consecutive cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; updates happen on the rising edge |
| rst_ni | input | 1 | Asynchronous system reset, active low; clears the counter |
| ext_addr_i | input | ADDR_W | Externally supplied address |
| strobe_ni | input | 1 | Active low; use and load the external address |
| adv_ni | input | 1 | Active low; advance the counter by one |
| clr_ni | input | 1 | Active low; force the address to zero |
| int_addr_o | output | ADDR_W | Address for the access in this cycle |
| count_o | output | ADDR_W | Registered counter value |

## Verification
The bench drives conflicting controls in the same cycle, so that a design with the wrong priority is caught. Two such designs would be one that advances while a load or clear is asserted, and one that loads while a clear is asserted. It advances from all ones to show whether the count wraps to zero or sticks at the top. It also changes the external bus while the counter holds, so that a design which lets the bus leak into a held count is caught. The same-cycle checks on the internal address catch a design that uses the strobed address or the cleared zero one cycle late.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_INC  = 2'd2,
    SRC_HOLD = 2'd3
  } addr_src_e;
endpackage

// File: rtl/burst_src_decode.sv
module burst_src_decode
  import burst_addr_pkg::*;
(
  input  logic      strobe_ni,
  input  logic      adv_ni,
  input  logic      clr_ni,
  output addr_src_e src_o
);
  // fixed priority: clear > strobe > advance > hold
  always_comb begin
    if (!clr_ni)         src_o = SRC_ZERO;
    else if (!strobe_ni) src_o = SRC_EXT;
    else if (!adv_ni)    src_o = SRC_INC;
    else                 src_o = SRC_HOLD;
  end
endmodule

// File: rtl/burst_addr_mux.sv
module burst_addr_mux
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_src_e         src_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [ADDR_W-1:0] count_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] inc_addr;
  assign inc_addr = count_i + ADDR_W'(1);  // wraps naturally at width

  always_comb begin
    unique case (src_i)
      SRC_ZERO: addr_o = '0;
      SRC_EXT:  addr_o = ext_addr_i;
      SRC_INC:  addr_o = inc_addr;
      default:  addr_o = count_i;
    endcase
  end
endmodule

// File: rtl/burst_count_reg.sv
module burst_count_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              strobe_ni,
  input  logic              adv_ni,
  input  logic              clr_ni,
  output logic [ADDR_W-1:0] int_addr_o,
  output logic [ADDR_W-1:0] count_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  addr_src_e src;

  burst_src_decode u_dec (
    .strobe_ni (strobe_ni),
    .adv_ni    (adv_ni),
    .clr_ni    (clr_ni),
    .src_o     (src)
  );

  burst_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .src_i      (src),
    .ext_addr_i (ext_addr_i),
    .count_i    (count_o),
    .addr_o     (int_addr_o)
  );

  // counter captures the address used by this cycle's access
  burst_count_reg #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (int_addr_o),
    .q_o    (count_o)
  );

  assert_clr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (int_addr_o == '0));
  assert_clr_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (count_o == '0));
  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !strobe_ni) |=> (count_o == $past(ext_addr_i)));
  assert_same_cycle_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !strobe_ni) |-> (int_addr_o == ext_addr_i));
  assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && strobe_ni && !adv_ni) |=> (count_o == $past(count_o) + ADDR_W'(1)));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && strobe_ni && adv_ni) |=> $stable(count_o));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && strobe_ni && !adv_ni && count_o == TOP_ADDR) |=> (count_o == '0));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          strobe_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          clr_ni = 1'b1;
  logic [AW-1:0] int_addr_o;
  logic [AW-1:0] count_o;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_addr_i (ext_addr_i),
    .strobe_ni  (strobe_ni),
    .adv_ni     (adv_ni),
    .clr_ni     (clr_ni),
    .int_addr_o (int_addr_o),
    .count_o    (count_o)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, check same-cycle address, then registered count at next negedge
  task automatic step(input logic c, input logic s, input logic a, input logic [AW-1:0] ext,
                      input logic [AW-1:0] exp_int, input logic [AW-1:0] exp_cnt,
                      input string tag);
    clr_ni = c; strobe_ni = s; adv_ni = a; ext_addr_i = ext;
    #1;
    chk({tag, " int_addr"}, int_addr_o, exp_int);
    @(negedge clk_i);
    chk({tag, " count"}, count_o, exp_cnt);
  endtask

  task automatic t_reset_R1();
    chk("R1 reset count", count_o, '0);
    step(1, 1, 1, 16'hABCD, 16'h0000, 16'h0000, "R1 idle after reset");
  endtask

  task automatic t_load_R3_R8();
    step(1, 0, 1, 16'h1234, 16'h1234, 16'h1234, "R3/R8 load");
    step(1, 0, 1, 16'h00F0, 16'h00F0, 16'h00F0, "R8 reload");
  endtask

  task automatic t_adv_R4();
    step(1, 1, 0, 16'h5555, 16'h00F1, 16'h00F1, "R4 advance 1");
    step(1, 1, 0, 16'h5555, 16'h00F2, 16'h00F2, "R4 advance 2");
  endtask

  task automatic t_hold_R6();
    step(1, 1, 1, 16'h7777, 16'h00F2, 16'h00F2, "R6 hold a");
    step(1, 1, 1, 16'h8888, 16'h00F2, 16'h00F2, "R6 hold b");
  endtask

  task automatic t_priority_R5();
    step(1, 0, 0, 16'h0400, 16'h0400, 16'h0400, "R5 strobe beats advance");
    step(0, 0, 0, 16'h0999, 16'h0000, 16'h0000, "R5 clear beats strobe and advance");
  endtask

  task automatic t_clear_R2();
    step(1, 0, 1, 16'h3333, 16'h3333, 16'h3333, "R2 preload");
    step(0, 1, 1, 16'h4444, 16'h0000, 16'h0000, "R2 clear alone");
    step(1, 0, 1, 16'h2222, 16'h2222, 16'h2222, "R2 preload2");
    step(0, 1, 0, 16'h4444, 16'h0000, 16'h0000, "R2 clear with advance");
  endtask

  task automatic t_wrap_R7();
    step(1, 0, 1, 16'hFFFE, 16'hFFFE, 16'hFFFE, "R7 load near top");
    step(1, 1, 0, 16'h0000, 16'hFFFF, 16'hFFFF, "R7 reach top");
    step(1, 1, 0, 16'h0000, 16'h0000, 16'h0000, "R7 wrap");
  endtask

  task automatic t_no_dead_R9();
    step(1, 0, 1, 16'h0ABC, 16'h0ABC, 16'h0ABC, "R9 preload");
    step(0, 1, 1, 16'h0000, 16'h0000, 16'h0000, "R9 clear cycle");
    step(1, 1, 0, 16'h0000, 16'h0001, 16'h0001, "R9 next advance");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_R1();
    t_load_R3_R8();
    t_adv_R4();
    t_hold_R6();
    t_priority_R5();
    t_clear_R2();
    t_wrap_R7();
    t_no_dead_R9();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule